// File: doc/BRIEF.md
# Event Queue Producer and Notifier

This block owns the producer side of a circular event queue that lives in memory. An upstream agent hands it one event record at a time. The block works out where that record belongs in the ring and issues the memory write. It then advances its producer index and decides whether software must be told that new work is waiting.

Software is notified only on the transition from an empty queue to a non-empty one. The notice can leave the block in two ways. One is a message-signalled write of a configured payload to a configured address on the same memory write channel. The other is a level on a wired interrupt line that stays set until it is cleared. Each path has its own gating. The queue base, its log2 size, the consumer index, the interrupt control word, the capability word and the two message configuration words are all presented to the block as register values.

Top module: `evq_notify`

## Requirements
- R1: After reset, `prod_out` is 0, `irq_wire` is 0, `mw_valid` is 0 and `ev_ready` is 1.
- R2: The memory write for an accepted event goes to `{q_base[47:5], 5'b0} + 32 * (producer index modulo the entry count)`. Its data is the event record, and it is the first write issued after acceptance.
- R3: On each accepted event the producer becomes `(producer + 1)` masked to the index bits plus one wrap bit (bit L, where L is the effective log2 size). Every bit above that mask is cleared, including an overflow flag in bit 31.
- R4: The queue counts as empty when the producer and `cons_idx`, both masked as in R3, are equal just before the event. A notification is raised only when the queue was empty and `irq_ctrl[2]` is 1. Bits 0 and 1 of `irq_ctrl` have no effect.
- R5: A notification issues a second write only when `idr_caps[13]` is 1 and `msi_cfg0[47:2]` is non-zero. That write goes to `{msi_cfg0[47:2], 2'b00}` with data `msi_cfg1` zero-extended, and it is issued only after the event write has been accepted.
- R6: When a wired line is present, a notification sets `irq_wire` on the handshake of the event write, whatever the outcome of the message gating. `irq_wire` then stays high until `irq_clr` is pulsed.
- R7: Once `mw_valid` is high it stays high, with `mw_addr` and `mw_data` unchanged, until `mw_ready` is seen. `ev_ready` is low from acceptance until the last write of that event completes.
- R8: `prod_load` writes `prod_ld_val` into the producer unchanged. If an event is accepted in the same cycle, the advance of R3 takes priority and the load is ignored.
- R9: A `q_base[4:0]` value larger than `MAX_LOG2` is treated as `MAX_LOG2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ev_valid | input | 1 | An event record is offered |
| ev_ready | output | 1 | Block can take an event |
| ev_data | input | DATA_W | Event record payload |
| q_base | input | 64 | Queue base [47:5] and log2 entry count [4:0] |
| cons_idx | input | 32 | Consumer index register |
| prod_load | input | 1 | Load the producer register |
| prod_ld_val | input | 32 | Value for the producer load |
| prod_out | output | 32 | Current producer register |
| irq_ctrl | input | 32 | Interrupt control; bit 2 enables event notices |
| idr_caps | input | 32 | Capability word; bit 13 advertises message writes |
| msi_cfg0 | input | 64 | Message address in bits [47:2] |
| msi_cfg1 | input | 32 | Message payload |
| mw_valid | output | 1 | Memory write request valid |
| mw_ready | input | 1 | Memory write accepted |
| mw_addr | output | 48 | Memory write byte address |
| mw_data | output | DATA_W | Memory write data |
| irq_clr | input | 1 | Pulse to clear the wired line |
| irq_wire | output | 1 | Wired interrupt level |

## Verification
The bench builds the block with `MAX_LOG2 = 4`, `DATA_W = 64` and the wired line present. With a four-entry ring the producer wraps, and its wrap bit toggles, within a handful of events. A size field of 7 pushes the clamp of R9 onto a 16-entry ring that is still short enough to walk. Back-pressure on `mw_ready` follows a repeating pattern, so both the event write and the message write are held across stalled cycles.

// File: rtl/evq_pkg.sv
package evq_pkg;

  localparam int ADDR_W       = 48;
  localparam int ENTRY_SHIFT  = 5;
  localparam int IRQ_EVQ_BIT  = 2;
  localparam int CAP_MSI_BIT  = 13;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_EVT  = 2'd1,
    SEQ_MSG  = 2'd2
  } evq_seq_e;

endpackage

// File: rtl/evq_prod_index.sv
module evq_prod_index #(
  parameter int MAX_LOG2 = 16,
  parameter int PW       = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4:0]          log2_fld,
  input  logic [PW-1:0]       cons_idx,
  input  logic                accept,
  input  logic                ld_en,
  input  logic [PW-1:0]       ld_val,
  output logic [PW-1:0]       prod_q,
  output logic [MAX_LOG2-1:0] slot_idx,
  output logic                was_empty
);

  logic [4:0]    eff;
  logic [PW-1:0] smask;
  logic [PW-1:0] imask;
  logic [PW-1:0] prod_d;
  logic          prod_en;

  always_comb begin
    eff   = (log2_fld > 5'(MAX_LOG2)) ? 5'(MAX_LOG2) : log2_fld;
    smask = (PW'(1) << (eff + 5'd1)) - PW'(1);
    imask = (PW'(1) << eff) - PW'(1);
  end

  always_comb begin
    was_empty = ((prod_q ^ cons_idx) & smask) == '0;
    slot_idx  = MAX_LOG2'(prod_q & imask);
  end

  always_comb begin
    prod_en = accept | ld_en;
    if (accept)
      prod_d = (prod_q + PW'(1)) & smask;
    else
      prod_d = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prod_q <= '0;
    else if (prod_en)
      prod_q <= prod_d;
  end

  // R3: after an advance no bit above the wrap mask survives
  a_r3_masked_advance: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((prod_q & ~$past(smask)) == '0));

  // R8: a load with no accept lands unchanged
  a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !accept) |=> (prod_q == $past(ld_val)));

endmodule

// File: rtl/evq_write_seq.sv
module evq_write_seq
  import evq_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  output logic              accept,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              notify,
  input  logic              msg_ok,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [DATA_W-1:0] msg_data,
  input  logic              mw_ready,
  output logic              mw_valid,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [DATA_W-1:0] mw_data,
  output logic              wire_set
);

  evq_seq_e          st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [ADDR_W-1:0] maddr_q;
  logic [DATA_W-1:0] mdata_q;
  logic              mpend_q, mpend_d;
  logic              npend_q, npend_d;
  logic              snap_en;
  logic              beat_en;
  logic              hs;

  always_comb begin
    ev_ready = (st_q == SEQ_IDLE);
    accept   = ev_valid & ev_ready;
    mw_valid = (st_q != SEQ_IDLE);
    mw_addr  = addr_q;
    mw_data  = data_q;
    hs       = mw_valid & mw_ready;
    wire_set = (st_q == SEQ_EVT) & hs & npend_q;
  end

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    data_d  = data_q;
    mpend_d = mpend_q;
    npend_d = npend_q;
    snap_en = 1'b0;
    beat_en = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (accept) begin
          st_d    = SEQ_EVT;
          addr_d  = ev_addr;
          data_d  = ev_data;
          mpend_d = notify & msg_ok;
          npend_d = notify;
          snap_en = 1'b1;
          beat_en = 1'b1;
        end
      end
      SEQ_EVT: begin
        if (hs) begin
          npend_d = 1'b0;
          beat_en = 1'b1;
          if (mpend_q) begin
            st_d   = SEQ_MSG;
            addr_d = maddr_q;
            data_d = mdata_q;
          end else begin
            st_d = SEQ_IDLE;
          end
        end
      end
      SEQ_MSG: begin
        if (hs) begin
          st_d    = SEQ_IDLE;
          mpend_d = 1'b0;
          beat_en = 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      mpend_q <= 1'b0;
      npend_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      mpend_q <= mpend_d;
      npend_q <= npend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (beat_en) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maddr_q <= '0;
      mdata_q <= '0;
    end else if (snap_en) begin
      maddr_q <= msg_addr;
      mdata_q <= msg_data;
    end
  end

  // R7: a stalled request holds its payload
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

  // R7: no new event is taken while writes are outstanding
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ev_ready);

  // R5: the message write never targets address zero
  a_r5_msg_addr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_MSG) |-> (mw_addr != '0));

endmodule

// File: rtl/evq_wire_line.sv
module evq_wire_line #(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic line
);

  generate
    if (PRESENT) begin : g_line
      logic line_q, line_d;

      always_comb begin
        line_d = line_q;
        if (clr) line_d = 1'b0;
        if (set) line_d = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          line_q <= 1'b0;
        else
          line_q <= line_d;
      end

      assign line = line_q;

      // R6: the level only drops after a clear pulse
      a_r6_sticky_level: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_q) |-> $past(clr));
    end else begin : g_none
      assign line = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/evq_notify.sv
module evq_notify
  import evq_pkg::*;
#(
  parameter int MAX_LOG2     = 16,
  parameter int DATA_W       = 64,
  parameter bit WIRE_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [DATA_W-1:0] ev_data,
  input  logic [63:0]       q_base,
  input  logic [31:0]       cons_idx,
  input  logic              prod_load,
  input  logic [31:0]       prod_ld_val,
  output logic [31:0]       prod_out,
  input  logic [31:0]       irq_ctrl,
  input  logic [31:0]       idr_caps,
  input  logic [63:0]       msi_cfg0,
  input  logic [31:0]       msi_cfg1,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [47:0]       mw_addr,
  output logic [DATA_W-1:0] mw_data,
  input  logic              irq_clr,
  output logic              irq_wire
);

  logic [1:0]          rst_sync;
  logic                rst_s;
  logic                accept;
  logic                was_empty;
  logic [MAX_LOG2-1:0] slot_idx;
  logic [ADDR_W-1:0]   ev_addr;
  logic [ADDR_W-1:0]   msg_addr;
  logic [DATA_W-1:0]   msg_data;
  logic                notify;
  logic                msg_ok;
  logic                wire_set;
  logic                unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  always_comb begin
    ev_addr  = {q_base[47:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}}
             + ADDR_W'({slot_idx, {ENTRY_SHIFT{1'b0}}});
    msg_addr = {msi_cfg0[47:2], 2'b00};
    msg_data = DATA_W'(msi_cfg1);
    notify   = irq_ctrl[IRQ_EVQ_BIT] & was_empty;
    msg_ok   = idr_caps[CAP_MSI_BIT] & (msi_cfg0[47:2] != '0);
  end

  assign unused_bits = ^{q_base[63:48], irq_ctrl[31:3], irq_ctrl[1:0],
                         idr_caps[31:14], idr_caps[12:0],
                         msi_cfg0[63:48], msi_cfg0[1:0]};

  evq_prod_index #(
    .MAX_LOG2 (MAX_LOG2),
    .PW       (32)
  ) u_index (
    .clk       (clk),
    .rst_n     (rst_s),
    .log2_fld  (q_base[4:0]),
    .cons_idx  (cons_idx),
    .accept    (accept),
    .ld_en     (prod_load),
    .ld_val    (prod_ld_val),
    .prod_q    (prod_out),
    .slot_idx  (slot_idx),
    .was_empty (was_empty)
  );

  evq_write_seq #(
    .DATA_W (DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_s),
    .ev_valid (ev_valid),
    .ev_ready (ev_ready),
    .accept   (accept),
    .ev_addr  (ev_addr),
    .ev_data  (ev_data),
    .notify   (notify),
    .msg_ok   (msg_ok),
    .msg_addr (msg_addr),
    .msg_data (msg_data),
    .mw_ready (mw_ready),
    .mw_valid (mw_valid),
    .mw_addr  (mw_addr),
    .mw_data  (mw_data),
    .wire_set (wire_set)
  );

  evq_wire_line #(
    .PRESENT (WIRE_PRESENT)
  ) u_wire (
    .clk   (clk),
    .rst_n (rst_s),
    .set   (wire_set),
    .clr   (irq_clr),
    .line  (irq_wire)
  );

  // R6: the wired level only rises on a completed write handshake
  a_r6_rise_after_write: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(irq_wire) |-> $past(mw_valid && mw_ready));

  // R7: acceptance only happens with the write channel idle
  a_r7_accept_idle: assert property (@(posedge clk) disable iff (!rst_s)
    (ev_valid && ev_ready) |-> !mw_valid);

endmodule

// File: tb/evq_notify_test.sv
module evq_notify_test;

  localparam int CLK_P    = 10;
  localparam int MAXL     = 4;
  localparam int DW       = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ev_valid;
  logic          ev_ready;
  logic [DW-1:0] ev_data;
  logic [63:0]   q_base;
  logic [31:0]   cons_idx;
  logic          prod_load;
  logic [31:0]   prod_ld_val;
  logic [31:0]   prod_out;
  logic [31:0]   irq_ctrl;
  logic [31:0]   idr_caps;
  logic [63:0]   msi_cfg0;
  logic [31:0]   msi_cfg1;
  logic          mw_valid;
  logic          mw_ready;
  logic [47:0]   mw_addr;
  logic [DW-1:0] mw_data;
  logic          irq_clr;
  logic          irq_wire;

  int checks = 0;
  int errors = 0;
  logic [111:0] expq [$];
  logic [31:0]  mprod = 0;
  logic         exp_wire = 0;
  int           cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  evq_notify #(.MAX_LOG2(MAXL), .DATA_W(DW), .WIRE_PRESENT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_data(ev_data), .q_base(q_base), .cons_idx(cons_idx),
    .prod_load(prod_load), .prod_ld_val(prod_ld_val), .prod_out(prod_out),
    .irq_ctrl(irq_ctrl), .idr_caps(idr_caps), .msi_cfg0(msi_cfg0),
    .msi_cfg1(msi_cfg1), .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_addr(mw_addr), .mw_data(mw_data), .irq_clr(irq_clr), .irq_wire(irq_wire)
  );

  // back-pressure pattern, driven just after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 mw_ready <= (cyc % 3) != 1;
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected writes as handshakes happen
  always @(negedge clk) begin
    if (rst_n && mw_valid && mw_ready) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2/R5 unexpected write actual=%0h expected=none", mw_addr);
      end else begin
        logic [111:0] e;
        e = expq.pop_front();
        check("R2/R5 write addr", 128'(mw_addr), 128'(e[111:64]));
        check("R2/R5 write data", 128'(mw_data), 128'(e[63:0]));
      end
    end
  end

  function automatic int eff_l();
    return (int'(q_base[4:0]) > MAXL) ? MAXL : int'(q_base[4:0]);
  endfunction

  task automatic wait_idle();
    do @(negedge clk); while (!ev_ready);
  endtask

  task automatic send_event(input logic [DW-1:0] rec, input logic with_load);
    int L;
    logic [31:0] smask, imask;
    logic empty, notify;
    logic [47:0] a;
    L = eff_l();
    smask = (32'd1 << (L + 1)) - 1;
    imask = (32'd1 << L) - 1;
    empty = ((mprod ^ cons_idx) & smask) == 0;
    a = {q_base[47:5], 5'b0} + 48'((mprod & imask) << 5);
    expq.push_back({a, rec});
    notify = irq_ctrl[2] && empty;
    if (notify && idr_caps[13] && msi_cfg0[47:2] != 0)
      expq.push_back({msi_cfg0[47:2], 2'b00, 32'b0, msi_cfg1});
    if (notify) exp_wire = 1'b1;
    mprod = (mprod + 1) & smask;
    @(posedge clk); #1;
    ev_valid = 1'b1; ev_data = rec;
    if (with_load) begin prod_load = 1'b1; prod_ld_val = 32'h55; end
    do @(negedge clk); while (!ev_ready);
    @(posedge clk); #1;
    ev_valid = 1'b0; prod_load = 1'b0;
    wait_idle();
    check("R3 producer", 128'(prod_out), 128'(mprod));
    check("R6 wire level", 128'(irq_wire), 128'(exp_wire));
    check("R2 queue drained", 128'(expq.size()), 128'd0);
  endtask

  task automatic clear_wire();
    @(posedge clk); #1 irq_clr = 1'b1;
    @(posedge clk); #1 irq_clr = 1'b0;
    exp_wire = 1'b0;
    @(negedge clk);
    check("R6 clear", 128'(irq_wire), 128'd0);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    rst_n = 0; ev_valid = 0; ev_data = 0; prod_load = 0; prod_ld_val = 0;
    irq_clr = 0; mw_ready = 0;
    q_base   = 64'h0000_0000_8000_0000 | 64'd2;
    cons_idx = 0;
    irq_ctrl = 32'h4;
    idr_caps = 32'h2000;
    msi_cfg0 = 64'h0000_0000_4000_0010;
    msi_cfg1 = 32'h0000_ABCD;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 prod", 128'(prod_out), 128'd0);
    check("R1 wire", 128'(irq_wire), 128'd0);
    check("R1 mw_valid", 128'(mw_valid), 128'd0);
    check("R1 ev_ready", 128'(ev_ready), 128'd1);

    // R2 R4 R5 R6: empty queue, message and wire
    send_event(64'hE000_0000_0000_0001, 1'b0);
    // R4: non-empty, no notice; R6 level stays
    send_event(64'hE000_0000_0000_0002, 1'b0);
    clear_wire();
    // R4: consumer caught up, notice again
    cons_idx = 32'd2;
    send_event(64'hE000_0000_0000_0003, 1'b0);
    clear_wire();
    // R4: bit 2 clear, bits 0/1 set, no notice
    irq_ctrl = 32'h3; cons_idx = 32'd3;
    send_event(64'hE000_0000_0000_0004, 1'b0);
    check("R4 no notice", 128'(irq_wire), 128'd0);
    // R5 R6: capability off, wire only
    irq_ctrl = 32'h4; idr_caps = 32'h0; cons_idx = 32'd4;
    send_event(64'hE000_0000_0000_0005, 1'b0);
    clear_wire();
    // R5: zero address suppresses message, wire still set
    idr_caps = 32'h2000; msi_cfg0 = 64'h3; cons_idx = 32'd5;
    send_event(64'hE000_0000_0000_0006, 1'b0);
    clear_wire();
    msi_cfg0 = 64'h0000_0000_4000_0010;
    // R3: wrap through the 3-bit mask
    cons_idx = 32'd0;
    for (int i = 0; i < 5; i++) send_event(64'hE000_0000_0000_0100 + 64'(i), 1'b0);
    // R8: load with overflow flag, then R3 clears it
    @(posedge clk); #1 prod_load = 1; prod_ld_val = 32'h8000_0003;
    @(posedge clk); #1 prod_load = 0;
    @(negedge clk);
    check("R8 load", 128'(prod_out), 128'h8000_0003);
    mprod = 32'h8000_0003;
    send_event(64'hE000_0000_0000_0200, 1'b0);
    check("R3 overflow cleared", 128'(prod_out), 128'd4);
    // R8: load concurrent with accept is ignored
    send_event(64'hE000_0000_0000_0300, 1'b1);
    clear_wire();
    // R9: size field beyond MAX_LOG2 is clamped
    q_base = 64'h0000_0000_8000_0000 | 64'd7;
    @(posedge clk); #1 prod_load = 1; prod_ld_val = 32'h0000_001F;
    @(posedge clk); #1 prod_load = 0;
    mprod = 32'h1F; cons_idx = 32'h1F;
    send_event(64'hE000_0000_0000_0400, 1'b0);
    check("R9 clamp wrap", 128'(prod_out), 128'd0);
    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule